// File: doc/BRIEF.md
# Dual-rail return-to-zero pipeline

This block is a clocked model of a latch-free, four-phase, dual-rail pipeline made of identity stages. Each stage register holds one word as two rails per bit. When every rail is low the stage holds a spacer. When every bit has exactly one rail high the stage holds a full codeword. Each stage has a completion register that behaves like a C-element over the per-bit ORs. It rises once all bits are valid, falls once all rails are clear, and holds its value in between.

A stage moves only on what its successor reports. A stage precharges to spacer while the successor's completion is high. It evaluates, ORing in the predecessor's rails, while the successor's completion is low. As a result, data is removed only after the next stage has copied it, and new data enters only once the next stage is empty. Each timing event takes one clock cycle.

The producer drives a word when `in_ack_o` is low and returns to spacer once `in_ack_o` is high. The consumer raises `out_ack_i` after it has taken a full output word and lowers it once the output has returned to spacer. Inside the block, `out_ack_i` passes through one register that stands in for the completion state of a stage after the last one.

Top module: `dr_rtz_pipe`

## Requirements
- R1: While reset is asserted and at its release, every stage holds spacer, `out_t_o`/`out_f_o` are zero and `in_ack_o` is low.
- R2: Bit b carries one as t[b]=1,f[b]=0, zero as t[b]=0,f[b]=1, and spacer as both low. With legal input, no stage ever has both rails of a bit high, and words leave in the order they entered with their values unchanged.
- R3: While evaluating, a stage's rails only rise. A partially valid word never raises that stage's completion, so `in_ack_o` stays low and the output is not full until every bit has arrived.
- R4: A stage's rails fall only to full spacer, and only in the cycle after its successor's completion was high. No word is lost.
- R5: A stage's rails rise only in the cycle after its successor's completion was low. No word is delivered twice.
- R6: `in_ack_o` is stage 0's completion. It rises one cycle after stage 0 holds a full word, falls one cycle after stage 0 is all spacer, and otherwise holds.
- R7: `out_ack_i` is registered once. While that register is low, a full word at the output stays stable. Words held back by a stalled consumer are delivered once each after release.
- R8: In an empty pipeline, a word captured by stage 0 at edge k raises `in_ack_o` after edge k+1 and is full at the output after edge k+NUM_STAGES-1.
- R9: With a producer and consumer that answer at once, successive words leave the output 6 cycles apart.
- R10: Two adjacent stages never hold different full words. With the consumer stalled, the pipeline accepts at most ceil(NUM_STAGES/2) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one event per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset to spacer |
| in_t_i | input | DATA_W | Input true rails |
| in_f_i | input | DATA_W | Input false rails |
| in_ack_o | output | 1 | Acknowledge to producer (stage 0 completion) |
| out_t_o | output | DATA_W | Output true rails (last stage) |
| out_f_o | output | DATA_W | Output false rails (last stage) |
| out_ack_i | input | 1 | Acknowledge from consumer |

## Verification
The assertions check the handshake rules on every cycle, in every stage:
- rails fall only on a full precharge granted by the successor;
- rails rise only while the successor is empty;
- the input acknowledge tracks stage 0's completion;
- a stalled output holds;
- neighbours never carry two different tokens.

Other properties come only from the bench's scenarios, which push exhaustive word sweeps under several consumer delays. These are in-order delivery end to end, the exact fill latency, the six-cycle streaming period, the storage limit under a stalled consumer, and the handling of partial words.

// File: rtl/dr_pipe_pkg.sv
package dr_pipe_pkg;
  typedef enum logic {
    PH_EVAL      = 1'b0,
    PH_PRECHARGE = 1'b1
  } phase_e;
endpackage

// File: rtl/dr_completion.sv
// Per-bit OR merged by a registered C-element.
module dr_completion #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rail_t_i,
  input  logic [DATA_W-1:0] rail_f_i,
  output logic              done_o
);
  logic [DATA_W-1:0] bit_valid;
  logic all_set, all_clr, done_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign bit_valid[b] = rail_t_i[b] | rail_f_i[b];
  end

  assign all_set = &bit_valid;
  assign all_clr = ~|bit_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      done_q <= 1'b0;
    else if (all_set) done_q <= 1'b1;
    else if (all_clr) done_q <= 1'b0;
  end

  assign done_o = done_q;
endmodule

// File: rtl/dr_stage.sv
module dr_stage
  import dr_pipe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pred_t_i,
  input  logic [DATA_W-1:0] pred_f_i,
  input  logic              succ_done_i,
  output logic [DATA_W-1:0] rail_t_o,
  output logic [DATA_W-1:0] rail_f_o,
  output logic              done_o
);
  phase_e phase;
  logic [DATA_W-1:0] t_q, f_q;

  assign phase = succ_done_i ? PH_PRECHARGE : PH_EVAL;

  // evaluation is monotonic: rails may only be set, never cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
      f_q <= '0;
    end else begin
      unique case (phase)
        PH_PRECHARGE: begin
          t_q <= '0;
          f_q <= '0;
        end
        PH_EVAL: begin
          t_q <= t_q | pred_t_i;
          f_q <= f_q | pred_f_i;
        end
        default: ;
      endcase
    end
  end

  dr_completion #(.DATA_W(DATA_W)) u_cd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rail_t_i(t_q),
    .rail_f_i(f_q),
    .done_o  (done_o)
  );

  assign rail_t_o = t_q;
  assign rail_f_o = f_q;
endmodule

// File: rtl/dr_rtz_pipe.sv
module dr_rtz_pipe #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_t_i,
  input  logic [DATA_W-1:0] in_f_i,
  output logic              in_ack_o,
  output logic [DATA_W-1:0] out_t_o,
  output logic [DATA_W-1:0] out_f_o,
  input  logic              out_ack_i
);
  localparam int unsigned LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0][DATA_W-1:0] st_t, st_f;
  logic [NUM_STAGES-1:0]             st_done, succ_done;
  logic                              cons_done_q;

  // consumer ack registered: stands in for a successor completion register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cons_done_q <= 1'b0;
    else         cons_done_q <= out_ack_i;
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_st
    logic [DATA_W-1:0] pred_t, pred_f;

    if (s == 0) begin : g_head
      assign pred_t = in_t_i;
      assign pred_f = in_f_i;
    end else begin : g_body
      assign pred_t = st_t[s-1];
      assign pred_f = st_f[s-1];
    end

    if (s == LAST) begin : g_tail
      assign succ_done[s] = cons_done_q;
    end else begin : g_mid
      assign succ_done[s] = st_done[s+1];
    end

    dr_stage #(.DATA_W(DATA_W)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pred_t_i   (pred_t),
      .pred_f_i   (pred_f),
      .succ_done_i(succ_done[s]),
      .rail_t_o   (st_t[s]),
      .rail_f_o   (st_f[s]),
      .done_o     (st_done[s])
    );
  end

  assign in_ack_o = st_done[0];
  assign out_t_o  = st_t[LAST];
  assign out_f_o  = st_f[LAST];
endmodule

// File: rtl/dr_rtz_pipe_chk.sv
module dr_rtz_pipe_chk #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned DATA_W     = 8
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [DATA_W-1:0]                 in_t_i,
  input logic [DATA_W-1:0]                 in_f_i,
  input logic                              in_ack_o,
  input logic [NUM_STAGES-1:0][DATA_W-1:0] st_t,
  input logic [NUM_STAGES-1:0][DATA_W-1:0] st_f,
  input logic [NUM_STAGES-1:0]             succ_done
);
  localparam int unsigned LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] st_full, st_empty;

  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      st_full[s]  = &(st_t[s] | st_f[s]);
      st_empty[s] = ~|(st_t[s] | st_f[s]);
    end
  end

  p_input_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_t_i & in_f_i) == '0);

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_chk
    p_legal_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_t[s] & st_f[s]) == '0);

    p_fall_on_precharge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|($past(st_t[s]) & ~st_t[s])) || (|($past(st_f[s]) & ~st_f[s])))
      |-> (st_empty[s] && $past(succ_done[s])));

    p_rise_on_eval_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|(st_t[s] & ~$past(st_t[s]))) || (|(st_f[s] & ~$past(st_f[s]))))
      |-> !$past(succ_done[s]));

    if (s < LAST) begin : g_pair
      p_spacer_between_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_full[s] && st_full[s+1]) |-> (st_t[s] == st_t[s+1]));
    end
  end

  p_ack_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> $past(st_full[0]));

  p_ack_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ack_o) |-> $past(st_empty[0]));

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_full[LAST] && !succ_done[LAST]) |=> ($stable(st_t[LAST]) && $stable(st_f[LAST])));
endmodule

bind dr_rtz_pipe dr_rtz_pipe_chk #(
  .NUM_STAGES(NUM_STAGES),
  .DATA_W    (DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .in_t_i   (in_t_i),
  .in_f_i   (in_f_i),
  .in_ack_o (in_ack_o),
  .st_t     (st_t),
  .st_f     (st_f),
  .succ_done(succ_done)
);

// File: tb/dr_rtz_pipe_test.sv
module dr_rtz_pipe_test;
  localparam int S = 4;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] in_t = '0, in_f = '0;
  logic [W-1:0] out_t, out_f;
  logic in_ack;
  logic out_ack = 1'b0;

  int total = 0, bad = 0;
  int cyc = 0;
  int exp_q[$];
  int recv_cnt = 0, sent_cnt = 0, accepted = 0, illegal = 0;
  int arr_cyc[0:127];
  int cons_delay = 0;
  bit stall = 1'b0;

  dr_rtz_pipe #(.NUM_STAGES(S), .DATA_W(W)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .in_t_i   (in_t),
    .in_f_i   (in_f),
    .in_ack_o (in_ack),
    .out_t_o  (out_t),
    .out_f_o  (out_f),
    .out_ack_i(out_ack)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // consumer: raise ack after cons_delay full cycles, drop it on spacer
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        out_ack = 1'b0;
        wait_cnt = 0;
      end else begin
        if ((out_t & out_f) != '0) illegal++;
        if (!out_ack && (&(out_t | out_f))) begin
          if (!stall && wait_cnt >= cons_delay) begin
            chk(out_f == ~out_t, "R2 rails complementary", int'(out_f), int'(~out_t));
            if (exp_q.size() == 0) begin
              chk(1'b0, "R5 extra word", int'(out_t), -1);
            end else begin
              int e;
              e = exp_q.pop_front();
              chk(int'(out_t) == e, "R2 order/value", int'(out_t), e);
            end
            arr_cyc[recv_cnt] = cyc;
            recv_cnt++;
            out_ack = 1'b1;
            wait_cnt = 0;
          end else if (!stall) begin
            wait_cnt++;
          end
        end else if (out_ack && ((out_t | out_f) == '0)) begin
          out_ack = 1'b0;
        end
      end
    end
  end

  task automatic send_word(input int w);
    @(negedge clk);
    while (in_ack) @(negedge clk);
    exp_q.push_back(w);
    sent_cnt++;
    in_t = w[W-1:0];
    in_f = ~w[W-1:0];
    @(negedge clk);
    while (!in_ack) @(negedge clk);
    accepted++;
    in_t = '0;
    in_f = '0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_t == '0 && out_f == '0, "R1 output spacer in reset", int'({out_t, out_f}), 0);
    chk(in_ack == 1'b0, "R1 in_ack low in reset", int'(in_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_t == '0 && out_f == '0 && !in_ack, "R1 after release", int'({in_ack, out_t, out_f}), 0);

    // R8/R6: fill latency on an empty pipeline
    exp_q.push_back(5);
    sent_cnt++;
    in_t = 3'b101;
    in_f = 3'b010;
    @(negedge clk);
    chk(in_ack == 1'b0, "R6 ack not before completion register", int'(in_ack), 0);
    @(negedge clk);
    chk(in_ack == 1'b1, "R8 ack one cycle after capture", int'(in_ack), 1);
    in_t = '0;
    in_f = '0;
    repeat (S - 3) @(negedge clk);
    chk(!(&(out_t | out_f)), "R8 output not early", int'(out_t | out_f), 0);
    @(negedge clk);
    chk((&(out_t | out_f)) && out_t == 3'b101, "R8 output at latency", int'(out_t), 5);
    wait_drain();
    chk(!in_ack, "R6 ack falls after spacer", int'(in_ack), 0);

    // R3/R6: partial word arriving bit by bit (word 3'b101)
    exp_q.push_back(5);
    sent_cnt++;
    @(negedge clk);
    in_t[0] = 1'b1;
    @(negedge clk);
    in_f[1] = 1'b1;
    @(negedge clk);
    chk(in_ack == 1'b0, "R3 partial word no ack", int'(in_ack), 0);
    in_t[2] = 1'b1;
    @(negedge clk);
    chk(in_ack == 1'b0, "R3 ack waits for register", int'(in_ack), 0);
    chk(!(&(out_t | out_f)), "R3 output not full on partial", int'(out_t | out_f), 0);
    @(negedge clk);
    chk(in_ack == 1'b1, "R6 ack after full word", int'(in_ack), 1);
    in_t = '0;
    in_f = '0;
    wait_drain();

    // R10/R7: stalled consumer, capacity and hold
    begin
      int acc0;
      acc0 = accepted;
      stall = 1'b1;
      fork
        begin
          for (int w = 1; w <= 4; w++) send_word(w);
        end
        begin
          repeat (60) @(negedge clk);
          chk(accepted - acc0 == (S + 1) / 2, "R10 capacity", accepted - acc0, (S + 1) / 2);
          chk((&(out_t | out_f)) && out_t == 3'd1, "R7 output holds first word", int'(out_t), 1);
          repeat (5) @(negedge clk);
          chk(out_t == 3'd1 && out_f == 3'd6, "R7 output stable while stalled", int'(out_t), 1);
          stall = 1'b0;
        end
      join
      wait_drain();
      chk(exp_q.size() == 0, "R7 stalled words delivered", exp_q.size(), 0);
    end

    // exhaustive sweep of words under several consumer delays
    for (int d = 0; d < 4; d++) begin
      int base;
      cons_delay = d;
      base = recv_cnt;
      for (int w = 0; w < 8; w++) send_word(w ^ d);
      wait_drain();
      chk(recv_cnt - base == 8, "R4 sweep count", recv_cnt - base, 8);
      if (d == 0) begin
        for (int i = 1; i < 8; i++)
          chk(arr_cyc[base + i] - arr_cyc[base + i - 1] == 6, "R9 period",
              arr_cyc[base + i] - arr_cyc[base + i - 1], 6);
      end
    end

    chk(exp_q.size() == 0, "R4 no word lost", exp_q.size(), 0);
    chk(recv_cnt == sent_cnt, "R5 no duplicate", recv_cnt, sent_cnt);
    chk(illegal == 0, "R2 no illegal codeword", illegal, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule